// File: doc/BRIEF.md
# Split-Write 64-Bit Pointer Register

This block holds one 64-bit pointer, such as a ring base or a dequeue position, inside a slave whose register port is only 32 bits wide. A master that cannot issue 64-bit writes updates the pointer with two 32-bit writes. The low half goes in first and the high half second.

The low-half write only stages its data. The high-half write merges the staged low half with its own data and commits both halves in one cycle. The consumer behind the block therefore never sees a pointer with a new low half and an old high half. A one-cycle update strobe marks each commit. A high-half write that arrives with nothing staged still commits, using the low half already in place, and it raises a sticky ordering-error flag.

A parameter builds a 32-bit-only variant instead. In that variant the low-half write commits at once, writes to the high half are accepted and have no effect, and the high half reads back as zero. Read-back always returns the committed pointer, never the staged half.

Top module: `split_ptr_reg`

## Requirements
- R1: After reset, `ptr_value` is 0, `ptr_update` is 0, `order_err` is 0, and read-back of both halves returns 0.
- R2: With `WIDE_EN`=1, a write to the low-half address `LO_ADDR` (default 0x00) leaves `ptr_value` unchanged and does not pulse `ptr_update`.
- R3: With `WIDE_EN`=1, a write to the high-half address `HI_ADDR` (default 0x04) while a low half is staged commits {write data, staged low} to `ptr_value`. The new value is visible from the first clock edge after the write. `ptr_update` is high for exactly that one cycle.
- R4: Several low-half writes before one high-half write stage only the last low-half data.
- R5: With `WIDE_EN`=1, a high-half write with no low half staged commits {write data, current committed low}, pulses `ptr_update` and sets `order_err`. A commit consumes the staged half, so a second high-half write in a row is an ordering error.
- R6: `order_err` stays set until reset.
- R7: `rd_data` returns `ptr_value[31:0]` when `rd_addr`=`LO_ADDR`, returns `ptr_value[63:32]` when `rd_addr`=`HI_ADDR`, and returns 0 at any other address. This is combinational from the committed value, so a staged half never appears on `rd_data`.
- R8: A write to any other address, or any cycle with `wr_en`=0, changes nothing.
- R9: With `WIDE_EN`=0, a low-half write commits {0, data} and pulses `ptr_update` one cycle later. High-half writes are ignored. `ptr_value[63:32]` is always 0, and `order_err` never sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, single cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 32 | Read-back of the committed half |
| ptr_value | output | 64 | Committed pointer seen by the consumer |
| ptr_update | output | 1 | One-cycle pulse after each commit |
| order_err | output | 1 | Sticky flag for a high-half write with no staged low half |

## Verification
A write held on the port during one cycle shows its effect on `ptr_value`, `ptr_update` and `order_err` right after the clock edge that samples it, because each is one register away from the port. The bench therefore drives at a falling edge, releases the strobe at the next falling edge, and compares all three outputs against its model at that point. At the following falling edge it confirms that `ptr_update` has dropped again. `rd_data` is combinational from the committed register, so it is checked a short delay after `rd_addr` changes, with the clock held between commits. A wide instance and a 32-bit-only instance share the same stimulus and each is compared against its own model.

// File: rtl/spr_pkg.sv
package spr_pkg;
  localparam int HALF_W = 32;
  localparam int PTR_W  = 2 * HALF_W;

  typedef logic [HALF_W-1:0] half_t;
  typedef logic [PTR_W-1:0]  ptr_t;

  // Assemble a full pointer from its two halves.
  function automatic ptr_t join_halves(input half_t upper, input half_t lower);
    return {upper, lower};
  endfunction

  // Pick the lower half for a commit: the staged one if present, else the held one.
  function automatic half_t low_source(input logic pend, input half_t staged, input half_t held);
    return pend ? staged : held;
  endfunction

  // Select one half of a pointer for read-back.
  function automatic half_t read_half(input ptr_t v, input logic upper);
    return upper ? v[PTR_W-1:HALF_W] : v[HALF_W-1:0];
  endfunction
endpackage

// File: rtl/spr_decode.sv
module spr_decode #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] LO_ADDR = 'h0,
  parameter logic [ADDR_W-1:0] HI_ADDR = 'h4
) (
  input  logic              en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              lo_wr,
  output logic              hi_wr,
  output logic              rd_lo,
  output logic              rd_hi
);
  assign lo_wr = en && (wr_addr == LO_ADDR);
  assign hi_wr = en && (wr_addr == HI_ADDR);
  assign rd_lo = (rd_addr == LO_ADDR);
  assign rd_hi = (rd_addr == HI_ADDR);
endmodule

// File: rtl/spr_stage.sv
module spr_stage
  import spr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  lo_wr,
  input  logic  hi_wr,
  input  half_t wdata,
  output half_t stage_q,
  output logic  pend_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      pend_q  <= 1'b0;
    end else if (lo_wr) begin
      stage_q <= wdata;
      pend_q  <= 1'b1;
    end else if (hi_wr) begin
      pend_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/spr_commit.sv
module spr_commit
  import spr_pkg::*;
#(
  parameter bit WIDE_EN = 1'b1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  lo_wr,
  input  logic  hi_wr,
  input  half_t wdata,
  input  half_t stage_lo,
  input  logic  pend,
  output ptr_t  ptr_q,
  output logic  upd_q,
  output logic  err_q
);
  generate
    if (WIDE_EN) begin : g_wide
      logic unused_lo;
      assign unused_lo = lo_wr;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ptr_q <= '0;
          upd_q <= 1'b0;
          err_q <= 1'b0;
        end else begin
          upd_q <= hi_wr;
          if (hi_wr) begin
            ptr_q <= join_halves(wdata, low_source(pend, stage_lo, ptr_q[HALF_W-1:0]));
            if (!pend) err_q <= 1'b1;
          end
        end
      end
    end else begin : g_narrow
      logic unused_hi;
      assign unused_hi = ^{hi_wr, stage_lo, pend};
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ptr_q <= '0;
          upd_q <= 1'b0;
        end else begin
          upd_q <= lo_wr;
          if (lo_wr) ptr_q <= join_halves('0, wdata);
        end
      end
      assign err_q = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/split_ptr_reg.sv
module split_ptr_reg
  import spr_pkg::*;
#(
  parameter bit WIDE_EN = 1'b1,
  parameter int ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] LO_ADDR = 'h0,
  parameter logic [ADDR_W-1:0] HI_ADDR = 'h4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic [63:0]       ptr_value,
  output logic              ptr_update,
  output logic              order_err
);
  // Named internal events, visible to the bound checker.
  logic  lo_wr, hi_wr, rd_lo, rd_hi;
  half_t stage_lo;
  logic  stage_pend;
  ptr_t  ptr_q;

  spr_decode #(.ADDR_W(ADDR_W), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)) u_dec (
    .en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr),
    .lo_wr(lo_wr), .hi_wr(hi_wr), .rd_lo(rd_lo), .rd_hi(rd_hi)
  );

  generate
    if (WIDE_EN) begin : g_stage
      spr_stage u_stage (
        .clk(clk), .rst_n(rst_n), .lo_wr(lo_wr), .hi_wr(hi_wr),
        .wdata(wr_data), .stage_q(stage_lo), .pend_q(stage_pend)
      );
    end else begin : g_nostage
      assign stage_lo   = '0;
      assign stage_pend = 1'b0;
    end
  endgenerate

  spr_commit #(.WIDE_EN(WIDE_EN)) u_commit (
    .clk(clk), .rst_n(rst_n), .lo_wr(lo_wr), .hi_wr(hi_wr), .wdata(wr_data),
    .stage_lo(stage_lo), .pend(stage_pend),
    .ptr_q(ptr_q), .upd_q(ptr_update), .err_q(order_err)
  );

  assign ptr_value = ptr_q;
  assign rd_data   = rd_lo ? read_half(ptr_q, 1'b0) :
                     rd_hi ? read_half(ptr_q, 1'b1) : '0;
endmodule

// File: rtl/spr_chk.sv
module spr_chk #(
  parameter bit WIDE_EN = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        lo_wr,
  input logic        hi_wr,
  input logic        stage_pend,
  input logic [31:0] wr_data,
  input logic [63:0] ptr_value,
  input logic        ptr_update,
  input logic        order_err
);
  // R2
  lo_stage_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (WIDE_EN && lo_wr) |=> ($stable(ptr_value) && !ptr_update));

  // R3
  hi_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (WIDE_EN && hi_wr && stage_pend) |=> (ptr_update && ptr_value[63:32] == $past(wr_data)));

  // R5
  order_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (WIDE_EN && hi_wr && !stage_pend) |=>
      (order_err && ptr_value[31:0] == $past(ptr_value[31:0])));

  // R6
  sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    order_err |=> order_err);

  // R8
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ptr_update |-> $stable(ptr_value));

  // R3
  strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_update |-> $past(lo_wr || hi_wr));

  // R9
  narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !WIDE_EN |-> (ptr_value[63:32] == 32'h0 && !order_err));
endmodule

bind split_ptr_reg spr_chk #(.WIDE_EN(WIDE_EN)) u_chk (
  .clk(clk), .rst_n(rst_n), .lo_wr(lo_wr), .hi_wr(hi_wr),
  .stage_pend(stage_pend), .wr_data(wr_data), .ptr_value(ptr_value),
  .ptr_update(ptr_update), .order_err(order_err)
);

// File: tb/sim_split_ptr_reg.sv
`timescale 1ns/1ps
module sim_split_ptr_reg;
  localparam logic [7:0] LO = 8'h00;
  localparam logic [7:0] HI = 8'h04;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] w_rd, n_rd;
  logic [63:0] w_val, n_val;
  logic        w_upd, n_upd, w_err, n_err;

  int checks = 0;
  int errors = 0;

  // Model state
  logic [63:0] m_val, mn_val;
  logic [31:0] m_stage;
  logic        m_pend, m_err;

  always #2.5 clk = ~clk;

  split_ptr_reg #(.WIDE_EN(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(w_rd), .ptr_value(w_val), .ptr_update(w_upd),
    .order_err(w_err)
  );

  split_ptr_reg #(.WIDE_EN(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(n_rd), .ptr_value(n_val), .ptr_update(n_upd),
    .order_err(n_err)
  );

  function automatic logic [63:0] after_hi(input logic [31:0] d, input logic pend,
                                           input logic [31:0] stg, input logic [63:0] old);
    logic [31:0] low;
    low = old[31:0];
    if (pend) low = stg;
    return {d, low};
  endfunction

  function automatic logic [31:0] exp_read(input logic [63:0] v, input logic [7:0] a);
    if (a == LO) return v[31:0];
    if (a == HI) return v[63:32];
    return 32'h0;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_read();
    for (int k = 0; k < 3; k++) begin
      logic [7:0] a;
      a = (k == 0) ? LO : (k == 1) ? HI : 8'h08;
      rd_addr = a;
      #1;
      chk("R7 wide read", w_rd, exp_read(m_val, a));
      chk("R7 narrow read R9", n_rd, exp_read(mn_val, a));
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    m_val = '0; mn_val = '0; m_stage = '0; m_pend = 1'b0; m_err = 1'b0;
    chk("R1 ptr", w_val, 64'h0);
    chk("R1 upd", w_upd, 0);
    chk("R1 err", w_err, 0);
    chk("R1 narrow ptr", n_val, 64'h0);
    chk_read();
    rst_n = 1'b1;
  endtask

  task automatic do_wr(input logic en, input logic [7:0] a, input logic [31:0] d,
                       input string tag);
    logic e_w, e_n, hi_np;
    @(negedge clk);
    chk("R3 strobe dropped", w_upd, 0);
    chk("R9 strobe dropped", n_upd, 0);
    wr_en = en; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    e_w = 1'b0; e_n = 1'b0; hi_np = 1'b0;
    if (en && a == LO) begin
      m_stage = d; m_pend = 1'b1;
      mn_val = {32'h0, d}; e_n = 1'b1;
    end else if (en && a == HI) begin
      hi_np = !m_pend;
      if (!m_pend) m_err = 1'b1;
      m_val = after_hi(d, m_pend, m_stage, m_val);
      m_pend = 1'b0; e_w = 1'b1;
    end
    chk(tag, w_val, m_val);
    chk(tag, w_upd, e_w);
    chk(hi_np ? "R5 err" : "R6 err", w_err, m_err);
    chk("R9 narrow value", n_val, mn_val);
    chk("R9 narrow upd", n_upd, e_n);
    chk("R9 narrow err", n_err, 0);
    chk_read();
  endtask

  // Watchdog
  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240917));
    do_reset();
    // Directed cases
    do_wr(1'b1, LO, 32'hAAAA_0001, "R2 low stages only");
    do_wr(1'b1, HI, 32'hBBBB_0002, "R3 atomic commit");
    do_wr(1'b1, HI, 32'hCCCC_0003, "R5 high without low");
    do_wr(1'b1, LO, 32'hDDDD_0004, "R2 low stages only");
    do_wr(1'b1, LO, 32'hEEEE_0005, "R4 restage");
    do_wr(1'b1, HI, 32'hFFFF_0006, "R4 last low wins");
    do_wr(1'b1, 8'h08, 32'h1234_5678, "R8 other address");
    do_wr(1'b0, LO, 32'h9999_9999, "R8 strobe low");
    do_wr(1'b0, HI, 32'h8888_8888, "R8 strobe low");
    do_wr(1'b1, LO, 32'h0000_0007, "R6 sticky");
    do_wr(1'b1, HI, 32'h0000_0008, "R6 sticky");
    do_reset();
    // Random traffic
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      logic en;
      string tag;
      a  = 8'(($urandom % 4) * 4);
      en = ($urandom % 8) != 0;
      if (!en || (a != LO && a != HI)) tag = "R8 no effect";
      else if (a == LO) tag = m_pend ? "R4 restage" : "R2 low stages only";
      else tag = m_pend ? "R3 atomic commit" : "R5 high without low";
      do_wr(en, a, $urandom, tag);
    end
    do_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule